// File: doc/BRIEF.md
# SPI Slave Serial Front End with Hold

This block is the pin-facing half of a small SPI slave peripheral. It watches chip select, the serial clock, the data input and an active-low hold pin, all brought into a fast system clock domain through multi-stage synchronisers. The serial clock is sampled, not used as a clock. On each rising serial clock edge it takes one bit, most significant bit first, and hands it to an inner command engine as a one-cycle strobe. A completed word is also delivered in parallel. On each falling serial clock edge it loads the engine's next output bit onto the serial output and tells the engine to advance.

Only SPI modes 0 and 3 are supported. In both modes data is taken on the rising edge and driven on the falling edge, so the block never looks at the idle clock level. A hold condition freezes the serial sequence in the middle of a word. While held, clock edges are ignored and the output driver is released, and the bit position is kept for when the hold ends. Deselecting the device at any time, during hold or not, throws the partial frame away. The engine sees frame boundaries as start and end strobes.

Top module: `spi_hold_frontend`

## Requirements
- R1: After the synchronous reset, `miso_oe_o`, `held_o`, `rx_valid_o`, `rx_word_valid_o`, `tx_take_o`, `frame_start_o` and `frame_end_o` are all 0.
- R2: While selected and not held, each rising serial clock edge yields one `rx_valid_o` pulse carrying the sampled data bit. The first pulse comes from the first rising edge after select. `rx_idx_o` counts 0 for the first (most significant) bit of a word up to WORD_W-1 for the last.
- R3: The pulse for the last bit of a word comes with `rx_word_valid_o`, and `rx_word_o` holds the word with the first received bit in its most significant position. The next bit starts a new word at index 0.
- R4: While selected and not held, each falling serial clock edge copies `tx_bit_i` to `miso_o` and pulses `tx_take_o` for one cycle. No falling edge is acted on during hold.
- R5: Transfers behave the same whether the clock idles low (mode 0) or high (mode 3).
- R6: A high-to-low transition of `hold_n_i` while selected and while the serial clock is low sets `held_o`. Such a transition while deselected has no effect.
- R7: While held, serial clock edges produce no received bits. The partial word and its bit position are kept, and the transfer continues from them after release.
- R8: A low-to-high transition of `hold_n_i` while the serial clock is low clears `held_o`. Transitions of `hold_n_i` while the serial clock is high are ignored, and the hold state is kept.
- R9: Deselecting during hold clears `held_o`. After reselect, reception starts a fresh word at index 0.
- R10: Deselecting mid-word clears the bit counter and the shift register, drives `miso_o` to 0 and drops `miso_oe_o`.
- R11: A falling edge of chip select gives one `frame_start_o` pulse, and a rising edge gives one `frame_end_o` pulse.
- R12: `miso_oe_o` is 1 while selected and not held, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data input pin |
| hold_n_i | input | 1 | Hold pin, active low |
| tx_bit_i | input | 1 | Next bit to send, supplied by the engine |
| miso_o | output | 1 | Serial data output value |
| miso_oe_o | output | 1 | Output enable for the serial data driver |
| held_o | output | 1 | Hold condition active |
| rx_valid_o | output | 1 | One-cycle strobe: a bit was received |
| rx_bit_o | output | 1 | Received bit value |
| rx_idx_o | output | $clog2(WORD_W) | Position of the received bit in its word |
| rx_word_valid_o | output | 1 | One-cycle strobe: a full word was received |
| rx_word_o | output | WORD_W | Last complete received word |
| tx_take_o | output | 1 | One-cycle strobe: `tx_bit_i` was consumed |
| frame_start_o | output | 1 | One-cycle strobe on select |
| frame_end_o | output | 1 | One-cycle strobe on deselect |

## Verification
Full words are sent in mode 0 and in mode 3 with distinct, asymmetric bit patterns. This shows that bit order and output loading do not depend on the idle clock level. Mode 0 also exposes the missing falling edge before the first bit. A hold is placed in the middle of a word, with clock toggles during it, to separate a frozen sequence from a lost or advanced one. Hold pin edges are then made while the clock is high and while deselected, to show that they are ignored. Deselects during hold and in mid-word are each followed by a complete word. A counter that failed to clear would then yield a wrong word or an early word strobe.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic {
    HOLD_RUN  = 1'b0,
    HOLD_STOP = 1'b1
  } hold_state_e;

  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCLK = 1;
  localparam int unsigned PIN_MOSI = 2;
  localparam int unsigned PIN_HOLD = 3;
  localparam int unsigned PIN_CNT  = 4;

  localparam logic [PIN_CNT-1:0] PIN_IDLE = 4'b1001;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
      prev <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    assign rise_o[g] =  chain[STAGES-1][g] & ~prev[g];
    assign fall_o[g] = ~chain[STAGES-1][g] &  prev[g];
  end

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold
  import spi_fe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic selected_i,
  input  logic sclk_lvl_i,
  input  logic hold_fall_i,
  input  logic hold_rise_i,
  output logic held_o
);

  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!selected_i) begin
      state_d = HOLD_RUN;
    end else begin
      unique case (state_q)
        HOLD_RUN:  if (hold_fall_i && !sclk_lvl_i) state_d = HOLD_STOP;
        HOLD_STOP: if (hold_rise_i && !sclk_lvl_i) state_d = HOLD_RUN;
        default:   state_d = HOLD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HOLD_RUN;
    else     state_q <= state_d;
  end

  assign held_o = (state_q == HOLD_STOP);

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selected_i,
  input  logic              held_i,
  input  logic              sclk_rise_i,
  input  logic              mosi_i,
  input  logic              sel_rise_i,
  input  logic              sel_fall_i,
  output logic              rx_valid_o,
  output logic              rx_bit_o,
  output logic [IDX_W-1:0]  rx_idx_o,
  output logic              rx_word_valid_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              frame_start_o,
  output logic              frame_end_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] shreg_nxt;

  assign shreg_nxt = {shreg_q[WORD_W-2:0], mosi_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q           <= '0;
      shreg_q         <= '0;
      rx_valid_o      <= 1'b0;
      rx_bit_o        <= 1'b0;
      rx_idx_o        <= '0;
      rx_word_valid_o <= 1'b0;
      rx_word_o       <= '0;
      frame_start_o   <= 1'b0;
      frame_end_o     <= 1'b0;
    end else begin
      rx_valid_o      <= 1'b0;
      rx_word_valid_o <= 1'b0;
      frame_start_o   <= sel_rise_i;
      frame_end_o     <= sel_fall_i;
      if (!selected_i) begin
        cnt_q   <= '0;
        shreg_q <= '0;
      end else if (sclk_rise_i && !held_i) begin
        rx_valid_o <= 1'b1;
        rx_bit_o   <= mosi_i;
        rx_idx_o   <= cnt_q;
        if (cnt_q == LAST_IDX) begin
          cnt_q           <= '0;
          shreg_q         <= '0;
          rx_word_valid_o <= 1'b1;
          rx_word_o       <= shreg_nxt;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          shreg_q <= shreg_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx (
  input  logic clk,
  input  logic rst,
  input  logic selected_i,
  input  logic held_i,
  input  logic sclk_fall_i,
  input  logic tx_bit_i,
  output logic miso_o,
  output logic miso_oe_o,
  output logic tx_take_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_o    <= 1'b0;
      miso_oe_o <= 1'b0;
      tx_take_o <= 1'b0;
    end else begin
      tx_take_o <= 1'b0;
      miso_oe_o <= selected_i && !held_i;
      if (!selected_i) begin
        miso_o <= 1'b0;
      end else if (sclk_fall_i && !held_i) begin
        miso_o    <= tx_bit_i;
        tx_take_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_fe_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  input  logic              tx_bit_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              held_o,
  output logic              rx_valid_o,
  output logic              rx_bit_o,
  output logic [IDX_W-1:0]  rx_idx_o,
  output logic              rx_word_valid_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              tx_take_o,
  output logic              frame_start_o,
  output logic              frame_end_o
);

  logic [PIN_CNT-1:0] pins, lvl, rise, fall;
  logic cs_n_s, sclk_s, selected;

  assign pins[PIN_CS]   = cs_n_i;
  assign pins[PIN_SCLK] = sclk_i;
  assign pins[PIN_MOSI] = mosi_i;
  assign pins[PIN_HOLD] = hold_n_i;

  spi_fe_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pins),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign cs_n_s   = lvl[PIN_CS];
  assign sclk_s   = lvl[PIN_SCLK];
  assign selected = ~cs_n_s;

  spi_fe_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .selected_i (selected),
    .sclk_lvl_i (sclk_s),
    .hold_fall_i(fall[PIN_HOLD]),
    .hold_rise_i(rise[PIN_HOLD]),
    .held_o     (held_o)
  );

  spi_fe_rx #(.WORD_W(WORD_W)) u_rx (
    .clk            (clk),
    .rst            (rst),
    .selected_i     (selected),
    .held_i         (held_o),
    .sclk_rise_i    (rise[PIN_SCLK]),
    .mosi_i         (lvl[PIN_MOSI]),
    .sel_rise_i     (fall[PIN_CS]),
    .sel_fall_i     (rise[PIN_CS]),
    .rx_valid_o     (rx_valid_o),
    .rx_bit_o       (rx_bit_o),
    .rx_idx_o       (rx_idx_o),
    .rx_word_valid_o(rx_word_valid_o),
    .rx_word_o      (rx_word_o),
    .frame_start_o  (frame_start_o),
    .frame_end_o    (frame_end_o)
  );

  spi_fe_tx u_tx (
    .clk        (clk),
    .rst        (rst),
    .selected_i (selected),
    .held_i     (held_o),
    .sclk_fall_i(fall[PIN_SCLK]),
    .tx_bit_i   (tx_bit_i),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .tx_take_o  (tx_take_o)
  );

endmodule

// File: rtl/spi_hold_frontend_chk.sv
module spi_hold_frontend_chk (
  input logic clk,
  input logic rst,
  input logic cs_n_s,
  input logic sclk_s,
  input logic held_o,
  input logic miso_oe_o,
  input logic rx_valid_o,
  input logic rx_word_valid_o,
  input logic tx_take_o,
  input logic frame_start_o,
  input logic frame_end_o
);

  assert_oe_off_in_hold_R12: assert property (@(posedge clk) disable iff (rst)
    held_o |=> !miso_oe_o);

  assert_no_rx_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $past(held_o) |-> !rx_valid_o);

  assert_no_tx_in_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $past(held_o) |-> !tx_take_o);

  assert_deselect_clears_hold_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !held_o);

  assert_deselect_drops_oe_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe_o);

  assert_hold_needs_low_clk_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(held_o) |-> $past(!sclk_s));

  assert_release_needs_low_clk_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(held_o) && !$past(cs_n_s)) |-> $past(!sclk_s));

  assert_word_on_last_bit_R3: assert property (@(posedge clk) disable iff (rst)
    rx_word_valid_o |-> rx_valid_o);

  assert_frame_pulse_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_start_o, frame_end_o}));

endmodule

bind spi_hold_frontend spi_hold_frontend_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cs_n_s         (cs_n_s),
  .sclk_s         (sclk_s),
  .held_o         (held_o),
  .miso_oe_o      (miso_oe_o),
  .rx_valid_o     (rx_valid_o),
  .rx_word_valid_o(rx_word_valid_o),
  .tx_take_o      (tx_take_o),
  .frame_start_o  (frame_start_o),
  .frame_end_o    (frame_end_o)
);

// File: tb/spi_hold_frontend_tb.sv
module spi_hold_frontend_tb_top;

  localparam int W = 8;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic tx_bit;
  logic miso, miso_oe, held, rx_valid, rx_bit, rx_word_valid, tx_take, fstart, fend;
  logic [2:0]   rx_idx;
  logic [W-1:0] rx_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  spi_hold_frontend #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .hold_n_i(hold_n), .tx_bit_i(tx_bit), .miso_o(miso), .miso_oe_o(miso_oe),
    .held_o(held), .rx_valid_o(rx_valid), .rx_bit_o(rx_bit), .rx_idx_o(rx_idx),
    .rx_word_valid_o(rx_word_valid), .rx_word_o(rx_word), .tx_take_o(tx_take),
    .frame_start_o(fstart), .frame_end_o(fend)
  );

  // engine model: presents bits of tx_pat, advances on tx_take
  logic [W-1:0] tx_pat = '0;
  logic         tx_load = 1'b0;
  logic [W-1:0] tx_new = '0;
  assign tx_bit = tx_pat[W-1];
  always @(posedge clk) begin
    if (tx_load)      tx_pat <= tx_new;
    else if (tx_take) tx_pat <= {tx_pat[W-2:0], 1'b0};
  end

  // monitor counters
  int rx_cnt = 0, word_cnt = 0, take_cnt = 0, fs_cnt = 0, fe_cnt = 0;
  logic [W-1:0] last_word = '0;
  logic [2:0]   last_idx  = '0;
  logic [2:0]   first_idx = '0;
  always @(posedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rx_cnt   <= rx_cnt + 1;
        last_idx <= rx_idx;
        if (rx_cnt == 0) first_idx <= rx_idx;
      end
      if (rx_word_valid) begin
        word_cnt  <= word_cnt + 1;
        last_word <= rx_word;
      end
      if (tx_take) take_cnt <= take_cnt + 1;
      if (fstart)  fs_cnt   <= fs_cnt + 1;
      if (fend)    fe_cnt   <= fe_cnt + 1;
    end
  end

  logic [W-1:0] cap = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_pat(input logic [W-1:0] p);
    @(negedge clk); tx_new = p; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0; mosi = b;
    wait_sys(H);
    cap = {cap[W-2:0], miso};
    sclk = 1'b1;
    wait_sys(H);
  endtask

  task automatic send_bits(input logic [W-1:0] v, input int from, input int n);
    for (int i = 0; i < n; i++) send_bit(v[W-1-from-i]);
  endtask

  task automatic select(input logic idle);
    sclk = idle; wait_sys(H);
    cs_n = 1'b0; wait_sys(H);
  endtask

  task automatic deselect();
    cs_n = 1'b1; wait_sys(H);
  endtask

  task automatic t_reset();
    chk("R1 miso_oe", miso_oe, 0);
    chk("R1 held", held, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 word_valid", rx_word_valid, 0);
    chk("R1 tx_take", tx_take, 0);
    chk("R1 frame pulses", {fstart, fend}, 0);
  endtask

  task automatic t_mode0();
    int fs0, fe0, w0, r0;
    fs0 = fs_cnt; fe0 = fe_cnt; w0 = word_cnt; r0 = rx_cnt;
    load_pat(8'hB3);
    cs_n = 1'b1; sclk = 1'b0; wait_sys(H);
    rx_cnt = 0; r0 = 0;
    select(1'b0);
    chk("R11 frame_start", fs_cnt - fs0, 1);
    chk("R12 oe selected", miso_oe, 1);
    send_bits(8'hA5, 0, 8);
    sclk = 1'b0; wait_sys(H);
    chk("R2 bit count", rx_cnt - r0, 8);
    chk("R2 first idx", first_idx, 0);
    chk("R2 last idx", last_idx, 7);
    chk("R3 word strobe", word_cnt - w0, 1);
    chk("R3 word value", last_word, 8'hA5);
    chk("R4 mode0 miso seq", cap, {1'b0, 7'h59});
    deselect();
    chk("R11 frame_end", fe_cnt - fe0, 1);
    chk("R12 oe deselected", miso_oe, 0);
  endtask

  task automatic t_mode3();
    int w0, t0;
    w0 = word_cnt;
    load_pat(8'h6D);
    t0 = take_cnt;
    select(1'b1);
    send_bits(8'h3C, 0, 8);
    chk("R5 mode3 word", last_word, 8'h3C);
    chk("R5 mode3 strobe", word_cnt - w0, 1);
    chk("R4 mode3 miso seq", cap, 8'h6D);
    chk("R4 tx_take count", take_cnt - t0, 8);
    deselect();
    sclk = 1'b0; wait_sys(H);
  endtask

  task automatic t_hold_mid();
    int r0, w0, t0;
    w0 = word_cnt;
    select(1'b0);
    send_bits(8'hC6, 0, 3);
    sclk = 1'b0; wait_sys(H);
    hold_n = 1'b0; wait_sys(H);
    chk("R6 held set", held, 1);
    chk("R12 oe off in hold", miso_oe, 0);
    r0 = rx_cnt; t0 = take_cnt;
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; wait_sys(H);
      sclk = 1'b0; wait_sys(H);
    end
    chk("R7 no rx in hold", rx_cnt - r0, 0);
    chk("R4 no tx in hold", take_cnt - t0, 0);
    hold_n = 1'b1; wait_sys(H);
    chk("R8 released", held, 0);
    chk("R12 oe back", miso_oe, 1);
    send_bits(8'hC6, 3, 5);
    chk("R7 resumed word", last_word, 8'hC6);
    chk("R7 one word", word_cnt - w0, 1);
    sclk = 1'b0; wait_sys(H);
    deselect();
  endtask

  task automatic t_hold_clk_high();
    select(1'b0);
    sclk = 1'b1; wait_sys(H);
    hold_n = 1'b0; wait_sys(H);
    chk("R8 fall with clk high ignored", held, 0);
    sclk = 1'b0; wait_sys(H);
    chk("R8 still running", held, 0);
    hold_n = 1'b1; wait_sys(H);
    hold_n = 1'b0; wait_sys(H);
    chk("R6 held via low clk", held, 1);
    sclk = 1'b1; wait_sys(H);
    hold_n = 1'b1; wait_sys(H);
    chk("R8 rise with clk high ignored", held, 1);
    sclk = 1'b0; wait_sys(H);
    hold_n = 1'b0; wait_sys(H);
    hold_n = 1'b1; wait_sys(H);
    chk("R8 release with clk low", held, 0);
    deselect();
  endtask

  task automatic t_hold_deselected();
    hold_n = 1'b0; wait_sys(H);
    chk("R6 no hold when deselected", held, 0);
    select(1'b0);
    chk("R6 no hold after select", held, 0);
    hold_n = 1'b1; wait_sys(H);
    deselect();
  endtask

  task automatic t_deselect_in_hold();
    int w0;
    select(1'b0);
    send_bits(8'h0F, 0, 3);
    sclk = 1'b0; wait_sys(H);
    hold_n = 1'b0; wait_sys(H);
    chk("R6 held before deselect", held, 1);
    deselect();
    chk("R9 hold cleared", held, 0);
    hold_n = 1'b1; wait_sys(H);
    w0 = word_cnt;
    select(1'b0);
    send_bits(8'h5A, 0, 5);
    chk("R9 no early word", word_cnt - w0, 0);
    send_bits(8'h5A, 5, 3);
    chk("R9 fresh word", last_word, 8'h5A);
    chk("R9 one word", word_cnt - w0, 1);
    sclk = 1'b0; wait_sys(H);
    deselect();
  endtask

  task automatic t_abort_mid();
    int w0;
    load_pat(8'hFF);
    select(1'b0);
    send_bits(8'hE1, 0, 3);
    sclk = 1'b0; wait_sys(H);
    chk("R4 miso from engine", miso, 1);
    deselect();
    chk("R10 miso zero", miso, 0);
    chk("R10 oe off", miso_oe, 0);
    w0 = word_cnt;
    select(1'b0);
    send_bits(8'h96, 0, 8);
    chk("R10 clean word", last_word, 8'h96);
    chk("R10 one word", word_cnt - w0, 1);
    sclk = 1'b0; wait_sys(H);
    deselect();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode3();
    t_hold_mid();
    t_hold_clk_high();
    t_hold_deselected();
    t_deselect_in_hold();
    t_abort_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule